// File: doc/BRIEF.md
# Parallel Printer Port Register Model

This block is the byte-wide register front end of a legacy parallel printer port, with a simulated printer standing in for the cable. A host reaches three registers through a small I/O window using read and write strobes. Those registers are an outgoing data byte, the printer status and the port control. Every byte the host strobes out to the printer appears on a one-cycle valid output. The block also raises an interrupt request line when the host arms it.

The printer is not sampled from pins. Its BUSY/ACK replies advance one step on each status-register read, so a polling driver sees a plausible handshake with no real timing. A separate read latch samples an input byte every clock. A data-register read returns that latch when the control direction bit is set.

Top module: `lpt_printer_regs`

## Requirements
- R1: Only addr[2:0] is decoded, so the map repeats every 8 locations: offset 0 is data, offset 1 is status, offset 2 is control, and a read of offsets 3 to 7 returns 0xFF.
- R2: A data write (offset 0) stores the byte in the write latch. A data read returns the read latch when control bit 5 (direction) is 1, and the write latch otherwise. The read latch captures ext_in on every clock.
- R3: A control read (offset 2) returns the last byte written to control.
- R4: A control write with bit 2 (init) clear sets status to 0xD8, which is BUSY bit 7, ACK bit 6, ONLINE bit 4 and ERROR bit 3.
- R5: A control write with init = 1, select (bit 3) = 1 and strobe (bit 0) = 1 clears status BUSY. If the previous control value had strobe = 0, tx_valid is high for exactly the one cycle after the write, and tx_byte then holds the write latch.
- R6: The same write does not emit a byte when the previous control value already had strobe = 1.
- R7: A control write with init = 1, select = 1 and strobe = 0 sets the pending flag when the previous control value had bit 4 (interrupt enable) set. irq is the registered AND of the pending flag and the current enable bit, so it follows them one cycle later.
- R8: A status read (offset 1) returns the status value from before the read, and it clears the pending flag.
- R9: After a status read, when BUSY = 0 and control strobe = 0, the status changes: a set ACK is cleared, and a clear ACK sets both ACK and BUSY. In every other case the status is unchanged.
- R10: Reset clears the data latches, control, the pending flag, irq, tx_valid and rdata, and it sets status to 0x00.
- R11: Read data is registered and is valid the cycle after rd_en. It holds its value when no read takes place. When wr_en and rd_en are high together, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | I/O address; only bits 2:0 decoded |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| ext_in | input | 8 | Byte sampled into the read latch each clock |
| rdata | output | 8 | Registered read data |
| tx_valid | output | 1 | One-cycle pulse for a strobed-out byte |
| tx_byte | output | 8 | Byte sent to the printer |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that addr, wdata, wr_en and rd_en are stable around the rising edge. They also assume that each high cycle of a strobe is exactly one access. The interrupt-clear property further assumes that a status read is not combined with a write in the same cycle. The stimulus drives every input on the falling edge. It keeps each access to a single cycle and returns the strobes to zero in between. Its only overlap of read and write is the deliberate collision case, which is aimed at the data register.

// File: rtl/lpt_printer_regs.sv
module lpt_printer_regs #(
  parameter int ADDR_W = 16,
  parameter logic [7:0] UNMAPPED = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  input  logic [7:0]        ext_in,
  output logic [7:0]        rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              irq
);
  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;
  localparam int S_BUSY = 7, S_ACK = 6, S_ONL = 4, S_ERR = 3;
  localparam int C_STB = 0, C_INIT = 2, C_SEL = 3, C_IEN = 4, C_DIR = 5;
  localparam logic [7:0] STAT_FORCED = 8'((1 << S_BUSY) | (1 << S_ACK) | (1 << S_ONL) | (1 << S_ERR));

  logic [7:0] wlat_q, rlat_q, stat_q, ctrl_q, stat_d, rd_mux;
  logic       pend_q;

  wire [2:0] off     = addr[2:0];
  wire       rd_ok   = rd_en & ~wr_en;
  wire       wr_data = wr_en & (off == OFF_DATA);
  wire       wr_ctrl = wr_en & (off == OFF_CTRL);
  wire       rd_stat = rd_ok & (off == OFF_STAT);
  wire       hs_sel  = wdata[C_INIT] & wdata[C_SEL];
  wire       emit    = wr_ctrl & hs_sel & wdata[C_STB] & ~ctrl_q[C_STB];
  wire       arm     = wr_ctrl & hs_sel & ~wdata[C_STB] & ctrl_q[C_IEN];

  always_comb begin
    stat_d = stat_q;
    if (wr_ctrl) begin
      if (!wdata[C_INIT])
        stat_d = STAT_FORCED;
      else if (wdata[C_SEL] && wdata[C_STB])
        stat_d[S_BUSY] = 1'b0;
    end else if (rd_stat && !stat_q[S_BUSY] && !ctrl_q[C_STB]) begin
      if (stat_q[S_ACK]) begin
        stat_d[S_ACK] = 1'b0;
      end else begin
        stat_d[S_ACK]  = 1'b1;
        stat_d[S_BUSY] = 1'b1;
      end
    end
  end

  always_comb begin
    case (off)
      OFF_DATA: rd_mux = ctrl_q[C_DIR] ? rlat_q : wlat_q;
      OFF_STAT: rd_mux = stat_q;
      OFF_CTRL: rd_mux = ctrl_q;
      default:  rd_mux = UNMAPPED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wlat_q   <= '0;
      rlat_q   <= '0;
      stat_q   <= '0;
      ctrl_q   <= '0;
      pend_q   <= 1'b0;
      rdata    <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      irq      <= 1'b0;
    end else begin
      rlat_q   <= ext_in;
      stat_q   <= stat_d;
      tx_valid <= emit;
      irq      <= pend_q & ctrl_q[C_IEN];
      if (wr_data) wlat_q  <= wdata;
      if (wr_ctrl) ctrl_q  <= wdata;
      if (emit)    tx_byte <= wlat_q;
      if (rd_ok)   rdata   <= rd_mux;
      if (rd_stat)  pend_q <= 1'b0;
      else if (arm) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lpt_printer_regs_chk.sv
module lpt_printer_regs_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              tx_valid,
  input logic              irq,
  input logic [7:0]        stat
);
  p_tx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);

  p_tx_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(wr_en && addr[2:0] == 3'd2 && wdata[0] && wdata[2] && wdata[3]));

  p_tx_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !stat[7]);

  p_init_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[2:0] == 3'd2 && !wdata[2]) |=> stat == 8'hD8);

  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr[2:0] == 3'd1) |=> ##1 !irq);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> $stable(rdata));
endmodule

bind lpt_printer_regs lpt_printer_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .tx_valid(tx_valid), .irq(irq), .stat(stat_q)
);

// File: tb/lpt_printer_regs_tb.sv
`timescale 1ns/1ps
module lpt_printer_regs_tb;
  localparam int ADDR_W = 16;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = 0, ext_in = 0, rdata, tx_byte, v;
  logic tx_valid, irq;
  int errors = 0, checks = 0, cycles = 0;

  always #2.5 clk = ~clk;

  lpt_printer_regs #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .ext_in(ext_in), .rdata(rdata), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .irq(irq));

  int m_wl, m_rl, m_st, m_ct, m_pd, m_rd, m_tv, m_tb, m_irq;

  always @(posedge clk) begin
    int o, nst, nrd;
    cycles++;
    if (!rst_n) begin
      m_wl = 0; m_rl = 0; m_st = 0; m_ct = 0; m_pd = 0;
      m_rd = 0; m_tv = 0; m_tb = 0; m_irq = 0;
    end else begin
      o = int'(addr[2:0]);
      nst = m_st; nrd = m_rd;
      m_irq = (m_pd != 0 && (m_ct & 16) != 0) ? 1 : 0;
      m_tv = 0;
      if (rd_en && !wr_en) begin
        if (o == 0) nrd = (m_ct & 32) ? m_rl : m_wl;
        else if (o == 1) nrd = m_st;
        else if (o == 2) nrd = m_ct;
        else nrd = 255;
        if (o == 1) begin
          m_pd = 0;
          if ((m_st & 128) == 0 && (m_ct & 1) == 0)
            nst = (m_st & 64) ? (m_st - 64) : (m_st | 192);
        end
      end
      if (wr_en && o == 2) begin
        if ((wdata & 4) == 0) nst = 216;
        else if (wdata & 8) begin
          if (wdata & 1) begin
            nst = m_st & 127;
            if ((m_ct & 1) == 0) begin m_tv = 1; m_tb = m_wl; end
          end else if (m_ct & 16) m_pd = 1;
        end
        m_ct = int'(wdata);
      end
      if (wr_en && o == 0) m_wl = int'(wdata);
      m_rl = int'(ext_in);
      m_st = nst; m_rd = nrd;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(int'(rdata) == m_rd, "R8 rdata vs model", int'(rdata), m_rd);
    chk(int'(tx_valid) == m_tv, "R5 tx_valid vs model", int'(tx_valid), m_tv);
    if (tx_valid) chk(int'(tx_byte) == m_tb, "R5 tx_byte vs model", int'(tx_byte), m_tb);
    chk(int'(irq) == m_irq, "R7 irq vs model", int'(irq), m_irq);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; addr = ADDR_W'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] r);
    @(negedge clk); rd_en = 1; addr = ADDR_W'(a);
    @(negedge clk); rd_en = 0; r = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    while (cycles < 20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    finish_run();
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    chk(rdata == 0 && !tx_valid && !irq, "R10 reset outputs", int'(rdata), 0);
    rd(16'h3F9, v); chk(v == 8'h00, "R10 status after reset", v, 8'h00);
    rd(16'h3F9, v); chk(v == 8'hC0, "R9 ack+busy set", v, 8'hC0);
    rd(16'h3F9, v); chk(v == 8'hC0, "R9 busy holds", v, 8'hC0);
    wr(16'h3F8, 8'h5A);
    rd(16'h3F8, v); chk(v == 8'h5A, "R2 write latch readback", v, 8'h5A);
    wr(16'h00A, 8'h00);
    rd(16'h3F9, v); chk(v == 8'hD8, "R4 init forces status", v, 8'hD8);
    rd(16'h01A, v); chk(v == 8'h00, "R1 R3 aliased control read", v, 8'h00);
    wr(16'h3FA, 8'h0C);
    wr(16'h3FA, 8'h0D);
    chk(tx_valid && tx_byte == 8'h5A, "R5 byte emitted", int'(tx_byte), 8'h5A);
    idle(1); chk(!tx_valid, "R5 single pulse", int'(tx_valid), 0);
    wr(16'h3FA, 8'h0D); chk(!tx_valid, "R6 no re-emit", int'(tx_valid), 0);
    rd(16'h3F9, v); chk(v == 8'h58, "R5 busy cleared", v, 8'h58);
    rd(16'h3F9, v); chk(v == 8'h58, "R9 strobe high holds", v, 8'h58);
    wr(16'h3FA, 8'h1C); idle(2); chk(!irq, "R7 no arm without prior enable", int'(irq), 0);
    wr(16'h3FA, 8'h1C); chk(!irq, "R7 irq registered", int'(irq), 0);
    idle(1); chk(irq, "R7 irq raised", int'(irq), 1);
    wr(16'h3FA, 8'h0C); idle(1); chk(!irq, "R7 masked by enable", int'(irq), 0);
    wr(16'h3FA, 8'h1C); idle(1); chk(irq, "R7 pending kept", int'(irq), 1);
    rd(16'h3F9, v); chk(v == 8'h58, "R8 pre-read status", v, 8'h58);
    idle(1); chk(!irq, "R8 pending cleared", int'(irq), 0);
    rd(16'h3F9, v); chk(v == 8'h18, "R9 ack cleared", v, 8'h18);
    rd(16'h3F9, v); chk(v == 8'hD8, "R9 ack busy set", v, 8'hD8);
    ext_in = 8'hA5;
    wr(16'h3FA, 8'h2C);
    rd(16'h3F8, v); chk(v == 8'hA5, "R2 direction read latch", v, 8'hA5);
    wr(16'h3F8, 8'h33);
    rd(16'h3F8, v); chk(v == 8'hA5, "R2 read latch kept", v, 8'hA5);
    wr(16'h3FA, 8'h0C);
    rd(16'h3F8, v); chk(v == 8'h33, "R2 write latch again", v, 8'h33);
    rd(16'h3FD, v); chk(v == 8'hFF, "R1 unmapped offset", v, 8'hFF);
    @(negedge clk); wr_en = 1; rd_en = 1; addr = 16'h3F8; wdata = 8'h77;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk(rdata == 8'hFF, "R11 read ignored on collision", int'(rdata), 8'hFF);
    rd(16'h3F8, v); chk(v == 8'h77, "R11 write done on collision", v, 8'h77);
    wr(16'h3FA, 8'h0D); chk(tx_valid && tx_byte == 8'h77, "R5 second byte", int'(tx_byte), 8'h77);
    @(negedge clk); rst_n = 0; idle(2); rst_n = 1; idle(1);
    chk(rdata == 0 && !irq && !tx_valid, "R10 mid-run reset", int'(rdata), 0);
    rd(16'h3FA, v); chk(v == 8'h00, "R10 control cleared", v, 8'h00);
    rd(16'h3F9, v); chk(v == 8'h00, "R10 status cleared", v, 8'h00);
    idle(2);
    finish_run();
  end
endmodule